// File: doc/BRIEF.md
# Pipelined Dual-Mode CORDIC Engine

This block is a streaming circular-coordinate CORDIC datapath. Each clock it can take one sample made of a vector (X, Y), an angle Z and a mode bit. A valid strobe marks the sample. Every micro-rotation is one registered pipeline stage, so a new result can leave the block on every clock once the pipeline has filled. The mode bit travels down the pipeline with its sample, so rotation and vectoring samples can be mixed freely within one stream.

Rotation mode turns the vector by the angle Z. Feeding (A, 0) gives A·cos Z and A·sin Z. Vectoring mode turns the vector onto the positive X axis. X then holds the magnitude, and Z gains the vector's phase. A final registered stage multiplies X and Y by a constant that cancels the rotation gain, so the outputs are at unit scale. X and Y carry two guard bits inside the block, and the X and Y outputs keep that width.

Top module: `cordic_engine`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid is 0 and out_x, out_y and out_z are 0. Samples strobed during reset never produce an output.
- R2: Rotation mode (in_mode = 0): out_x ≈ x·cos θ − y·sin θ and out_y ≈ x·sin θ + y·cos θ, each within 40 LSB. The residual out_z is within 16 LSB of 0.
- R3: Vectoring mode (in_mode = 1, in_x > 0): out_x ≈ √(x²+y²) within 40 LSB, and out_y is within 40 LSB of 0. out_z ≈ in_z + atan2(y, x) within 16 LSB, modulo 2^ANG_W.
- R4: Each sample's result appears with out_valid = 1 exactly STAGES+1 clocks after the edge that accepts it. The default is 17 clocks.
- R5: Samples may be accepted on consecutive clocks with modes mixed arbitrarily. Each result is computed in its own sample's mode, and out_mode repeats that mode.
- R6: A clock with in_valid = 0 yields a clock with out_valid = 0 STAGES+1 clocks later. No output appears without a matching input.
- R7: The X and Y outputs are corrected for the CORDIC gain of about 1.6468. For example, rotating (20000, 0) by angle 0 gives out_x ≈ 20000.
- R8: Rotation converges for angles up to ±99° (codes ±18022).
- R9: Angles are two's-complement fractions of π on ANG_W bits: code 0x4000 is +90°, and 0x8000 is −180°.
- R10: Full-scale inputs (any in_x, in_y in the signed DATA_W range) produce correct results without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_mode | input | 1 | 0 = rotation, 1 = vectoring |
| in_x | input | DATA_W | Signed X component |
| in_y | input | DATA_W | Signed Y component |
| in_z | input | ANG_W | Angle, signed fraction of π |
| out_valid | output | 1 | Result strobe |
| out_mode | output | 1 | Mode of the sample in the output |
| out_x | output | DATA_W+2 | Signed X result (cosine term or magnitude) |
| out_y | output | DATA_W+2 | Signed Y result (sine term or residual) |
| out_z | output | ANG_W | Residual angle, or accumulated phase |

## Verification
The per-stage assertions assume three things about the inputs. Vectoring samples arrive with a positive X. Rotation angles stay inside the convergence range. No stage wraps its X or Y, which the two guard bits ensure for any DATA_W-range input. The random stimulus therefore draws vectoring X from 4096 upward and rotation angles from ±18000. X and Y use the full signed range, and directed samples push to the full-scale corners and to ±99°. Idle gaps and mode switches on consecutive clocks are mixed in, so the in-flight counter and the alignment of the mode bit are both exercised.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    typedef enum logic {
        MODE_ROT = 1'b0,
        MODE_VEC = 1'b1
    } cordic_mode_e;

    localparam real PI_R = 3.14159265358979323846;

    // arctan(2^-i) as a two's-complement fraction of pi, rounded to ang_w bits
    function automatic longint atan_code(input int i, input int ang_w);
        real units;
        units = $atan(2.0 ** (-i)) / PI_R * (2.0 ** (ang_w - 1));
        return longint'(units);
    endfunction

    // round(2^frac / K) where K is the gain of the given number of stages
    function automatic longint gain_inv_code(input int stages, input int frac);
        real k;
        k = 1.0;
        for (int i = 0; i < stages; i++) begin
            k = k / $sqrt(1.0 + 2.0 ** (-2 * i));
        end
        return longint'(k * (2.0 ** frac));
    endfunction

endpackage

// File: rtl/cordic_stage.sv
module cordic_stage
    import cordic_pkg::*;
#(
    parameter int W     = 18,
    parameter int ZW    = 16,
    parameter int SHIFT = 0,
    parameter logic signed [ZW-1:0] ANGLE = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_mode,
    input  logic signed [W-1:0]  in_x,
    input  logic signed [W-1:0]  in_y,
    input  logic signed [ZW-1:0] in_z,
    output logic                 out_valid,
    output logic                 out_mode,
    output logic signed [W-1:0]  out_x,
    output logic signed [W-1:0]  out_y,
    output logic signed [ZW-1:0] out_z
);

    typedef struct packed {
        logic                 valid;
        logic                 mode;
        logic signed [W-1:0]  x;
        logic signed [W-1:0]  y;
        logic signed [ZW-1:0] z;
    } stage_t;

    stage_t st_d, st_q;

    logic signed [W-1:0] x_sh, y_sh;
    logic                turn_ccw;

    always_comb begin
        x_sh     = in_x >>> SHIFT;
        y_sh     = in_y >>> SHIFT;
        turn_ccw = (in_mode == MODE_ROT) ? !in_z[ZW-1] : in_y[W-1];
        st_d.valid = in_valid;
        st_d.mode  = in_mode;
        if (turn_ccw) begin
            st_d.x = in_x - y_sh;
            st_d.y = in_y + x_sh;
            st_d.z = in_z - ANGLE;
        end else begin
            st_d.x = in_x + y_sh;
            st_d.y = in_y - x_sh;
            st_d.z = in_z + ANGLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_mode  = st_q.mode;
    assign out_x     = st_q.x;
    assign out_y     = st_q.y;
    assign out_z     = st_q.z;

    // checker: operands widened by one bit so negation cannot wrap
    localparam logic signed [ZW:0] ANG_E  = {ANGLE[ZW-1], ANGLE};
    localparam logic signed [ZW:0] ANG_E2 = ANG_E <<< 1;

    logic signed [ZW:0] zi_e, zo_e;
    logic signed [W:0]  xi_e, yi_e, xo_e, yo_e, xi_sh;
    assign zi_e  = {in_z[ZW-1], in_z};
    assign zo_e  = {out_z[ZW-1], out_z};
    assign xi_e  = {in_x[W-1], in_x};
    assign yi_e  = {in_y[W-1], in_y};
    assign xo_e  = {out_x[W-1], out_x};
    assign yo_e  = {out_y[W-1], out_y};
    assign xi_sh = xi_e >>> SHIFT;

    // rotation step moves the residual angle toward zero (R2)
    p_rot_z_shrink_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == MODE_ROT && zi_e <= ANG_E2 && zi_e >= -ANG_E2)
        |=> (zo_e <= $past(ANG_E) && zo_e >= -$past(ANG_E)));

    // vectoring step moves Y toward zero (R3)
    p_vec_y_shrink_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == MODE_VEC && xi_e > 0
         && yi_e <= (xi_sh <<< 1) && yi_e >= -(xi_sh <<< 1))
        |=> (yo_e <= $past(xi_sh) && yo_e >= -$past(xi_sh)));

    // vectoring step never shrinks a positive X (R3)
    p_vec_x_grow_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == MODE_VEC && xi_e > 0) |=> (xo_e >= $past(xi_e)));

endmodule

// File: rtl/cordic_gain.sv
module cordic_gain #(
    parameter int W       = 18,
    parameter int ZW      = 16,
    parameter int FRAC    = 16,
    parameter int COMP_EN = 1,
    parameter logic [FRAC+1:0] KINV = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_mode,
    input  logic signed [W-1:0]  in_x,
    input  logic signed [W-1:0]  in_y,
    input  logic signed [ZW-1:0] in_z,
    output logic                 out_valid,
    output logic                 out_mode,
    output logic signed [W-1:0]  out_x,
    output logic signed [W-1:0]  out_y,
    output logic signed [ZW-1:0] out_z
);

    localparam int PW = W + FRAC + 2;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);

    typedef struct packed {
        logic                 valid;
        logic                 mode;
        logic signed [W-1:0]  x;
        logic signed [W-1:0]  y;
        logic signed [ZW-1:0] z;
    } gain_t;

    gain_t g_d, g_q;
    logic signed [W-1:0] x_c, y_c;

    generate
        if (COMP_EN != 0) begin : g_comp
            logic signed [PW-1:0] k_e, x_e, y_e, x_p, y_p;
            always_comb begin
                k_e = $signed({{(PW-FRAC-2){1'b0}}, KINV});
                x_e = {{(PW-W){in_x[W-1]}}, in_x};
                y_e = {{(PW-W){in_y[W-1]}}, in_y};
                x_p = (x_e * k_e + HALF) >>> FRAC;
                y_p = (y_e * k_e + HALF) >>> FRAC;
                x_c = x_p[W-1:0];
                y_c = y_p[W-1:0];
            end
        end else begin : g_pass
            assign x_c = in_x;
            assign y_c = in_y;
        end
    endgenerate

    always_comb begin
        g_d.valid = in_valid;
        g_d.mode  = in_mode;
        g_d.x     = x_c;
        g_d.y     = y_c;
        g_d.z     = in_z;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign out_valid = g_q.valid;
    assign out_mode  = g_q.mode;
    assign out_x     = g_q.x;
    assign out_y     = g_q.y;
    assign out_z     = g_q.z;

    logic signed [W:0] ax_in, ax_out;
    assign ax_in  = in_x[W-1]  ? -{in_x[W-1], in_x}   : {1'b0, in_x};
    assign ax_out = out_x[W-1] ? -{out_x[W-1], out_x} : {1'b0, out_x};

    // gain correction never enlarges a component (R7)
    p_gain_shrink_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (ax_out <= $past(ax_in)));

endmodule

// File: rtl/cordic_engine.sv
module cordic_engine #(
    parameter int DATA_W    = 16,
    parameter int ANG_W     = 16,
    parameter int STAGES    = 16,
    parameter int COMP_FRAC = 16,
    parameter int COMP_EN   = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic                      in_mode,
    input  logic signed [DATA_W-1:0]  in_x,
    input  logic signed [DATA_W-1:0]  in_y,
    input  logic signed [ANG_W-1:0]   in_z,
    output logic                      out_valid,
    output logic                      out_mode,
    output logic signed [DATA_W+1:0]  out_x,
    output logic signed [DATA_W+1:0]  out_y,
    output logic signed [ANG_W-1:0]   out_z
);

    localparam int W   = DATA_W + 2;
    localparam int LAT = STAGES + 1;
    localparam longint KINV_L = cordic_pkg::gain_inv_code(STAGES, COMP_FRAC);
    localparam logic [COMP_FRAC+1:0] KINV = KINV_L[COMP_FRAC+1:0];

    logic                 v_s [0:STAGES];
    logic                 m_s [0:STAGES];
    logic signed [W-1:0]  x_s [0:STAGES];
    logic signed [W-1:0]  y_s [0:STAGES];
    logic signed [ANG_W-1:0] z_s [0:STAGES];

    assign v_s[0] = in_valid;
    assign m_s[0] = in_mode;
    assign x_s[0] = {{2{in_x[DATA_W-1]}}, in_x};
    assign y_s[0] = {{2{in_y[DATA_W-1]}}, in_y};
    assign z_s[0] = in_z;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            localparam longint ANG_L = cordic_pkg::atan_code(i, ANG_W);
            localparam logic signed [ANG_W-1:0] ANG_I = ANG_L[ANG_W-1:0];
            cordic_stage #(
                .W(W), .ZW(ANG_W), .SHIFT(i), .ANGLE(ANG_I)
            ) u_stage (
                .clk(clk), .rst(rst),
                .in_valid(v_s[i]), .in_mode(m_s[i]),
                .in_x(x_s[i]), .in_y(y_s[i]), .in_z(z_s[i]),
                .out_valid(v_s[i+1]), .out_mode(m_s[i+1]),
                .out_x(x_s[i+1]), .out_y(y_s[i+1]), .out_z(z_s[i+1])
            );
        end
    endgenerate

    cordic_gain #(
        .W(W), .ZW(ANG_W), .FRAC(COMP_FRAC), .COMP_EN(COMP_EN), .KINV(KINV)
    ) u_gain (
        .clk(clk), .rst(rst),
        .in_valid(v_s[STAGES]), .in_mode(m_s[STAGES]),
        .in_x(x_s[STAGES]), .in_y(y_s[STAGES]), .in_z(z_s[STAGES]),
        .out_valid(out_valid), .out_mode(out_mode),
        .out_x(out_x), .out_y(out_y), .out_z(out_z)
    );

    // checker: samples in flight between the ports
    localparam int CW = $clog2(LAT + 2) + 1;
    logic [CW-1:0] fly_d, fly_q;

    always_comb begin
        fly_d = fly_q;
        if (in_valid && !out_valid) fly_d = fly_q + CW'(1);
        if (!in_valid && out_valid) fly_d = fly_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fly_q <= '0;
        end else begin
            fly_q <= fly_d;
        end
    end

    p_inflight_bound_r4: assert property (@(posedge clk) disable iff (rst)
        fly_q <= CW'(LAT));

    p_out_has_source_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (fly_q != '0));

endmodule

// File: tb/cordic_engine_tb.sv
module cordic_engine_tb;

    localparam int DATA_W = 16;
    localparam int ANG_W  = 16;
    localparam int STAGES = 16;
    localparam int LAT    = STAGES + 1;
    localparam int TOL_XY = 40;
    localparam int TOL_Z  = 16;
    localparam real PI_R  = 3.14159265358979323846;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_mode = 1'b0;
    logic signed [DATA_W-1:0] in_x = '0, in_y = '0;
    logic signed [ANG_W-1:0]  in_z = '0;
    logic out_valid, out_mode;
    logic signed [DATA_W+1:0] out_x, out_y;
    logic signed [ANG_W-1:0]  out_z;

    always #4 clk = ~clk;

    cordic_engine u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .out_valid(out_valid), .out_mode(out_mode),
        .out_x(out_x), .out_y(out_y), .out_z(out_z)
    );

    typedef struct {
        bit    mode;
        int    x, y, z;
        int    issue;
        string tag;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int n_checks = 0;
    int n_fails = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)",
                     tag, what, act, expv, cyc);
        end
    endtask

    function automatic int wrap_ang(input int d);
        int r;
        r = (d + 32768) % 65536;
        if (r < 0) r += 65536;
        return r - 32768;
    endfunction

    function automatic int absi(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check_result(input exp_t e);
        real th, ex, ey, ez;
        int ax, ay, az;
        ax = int'(out_x);
        ay = int'(out_y);
        az = int'(out_z);
        chk(cyc - e.issue == LAT, {"R4 ", e.tag}, "latency", cyc - e.issue, LAT);
        chk(out_mode == e.mode, {"R5 ", e.tag}, "out_mode", int'(out_mode), int'(e.mode));
        if (e.mode == 1'b0) begin
            th = real'(e.z) * PI_R / 32768.0;
            ex = real'(e.x) * $cos(th) - real'(e.y) * $sin(th);
            ey = real'(e.x) * $sin(th) + real'(e.y) * $cos(th);
            chk(absi(ax - int'(ex)) <= TOL_XY, {"R2 ", e.tag}, "rot x", ax, int'(ex));
            chk(absi(ay - int'(ey)) <= TOL_XY, {"R2 ", e.tag}, "rot y", ay, int'(ey));
            chk(absi(wrap_ang(az)) <= TOL_Z, {"R2 ", e.tag}, "rot residual z", az, 0);
        end else begin
            ex = $sqrt(real'(e.x) * real'(e.x) + real'(e.y) * real'(e.y));
            ez = real'(e.z) + $atan2(real'(e.y), real'(e.x)) * 32768.0 / PI_R;
            chk(absi(ax - int'(ex)) <= TOL_XY, {"R3 ", e.tag}, "magnitude", ax, int'(ex));
            chk(absi(ay) <= TOL_XY, {"R3 ", e.tag}, "vec residual y", ay, 0);
            chk(absi(wrap_ang(az - int'(ez))) <= TOL_Z, {"R3 ", e.tag}, "phase",
                az, wrap_ang(int'(ez)));
        end
    endtask

    task automatic check_out();
        exp_t e;
        if (out_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R6", "output without input", 1, 0);
            end else begin
                e = q.pop_front();
                check_result(e);
            end
        end else if (q.size() != 0 && q[0].issue + LAT == cyc) begin
            chk(1'b0, {"R4 ", q[0].tag}, "missing out_valid", 0, 1);
            void'(q.pop_front());
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check_out();
    endtask

    task automatic send(input bit m, input int x, input int y, input int z,
                        input string tag);
        exp_t e;
        tick();
        in_valid = 1'b1;
        in_mode  = m;
        in_x     = x[DATA_W-1:0];
        in_y     = y[DATA_W-1:0];
        in_z     = z[ANG_W-1:0];
        e.mode = m; e.x = x; e.y = y; e.z = wrap_ang(z);
        e.issue = cyc; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            tick();
            in_valid = 1'b0;
        end
    endtask

    function automatic int rnd(input int lo, input int hi);
        return lo + int'($urandom_range(32'(hi - lo), 0));
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R4 watchdog expired: actual=%0d expected<%0d cycles", cyc, 60000);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: garbage strobed during reset must not leak out
        in_valid = 1'b1;
        in_x = 16'sd1234;
        in_y = -16'sd77;
        in_z = 16'sd3000;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(out_valid == 1'b0 && out_x == '0 && out_y == '0 && out_z == '0,
                "R1", "outputs in reset", int'(out_valid) + int'(out_x), 0);
        end
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_x == '0, "R1", "outputs after reset",
            int'(out_valid), 0);

        // R7: gain cancelled
        send(1'b0, 20000, 0, 0, "R7");
        send(1'b0, 0, -15000, 0, "R7");
        // R9: 0x4000 is +90 degrees, 0x8000 is -180
        send(1'b0, 10000, 0, 16384, "R9");
        send(1'b0, 10000, 0, -16384, "R9");
        send(1'b1, 0 + 12000, 12000, 0, "R9");
        // R8: convergence edge
        send(1'b0, 20000, 0, 18022, "R8");
        send(1'b0, 20000, 5000, -18022, "R8");
        // R10: full-scale corners
        send(1'b1, 32767, -32768, 0, "R10");
        send(1'b1, 32767, 32767, 4000, "R10");
        send(1'b0, -32768, -32768, 18000, "R10");
        send(1'b0, 32767, -32768, -9000, "R10");
        idle(LAT + 2);

        // R2 random rotation
        for (int k = 0; k < 500; k++)
            send(1'b0, rnd(-32768, 32767), rnd(-32768, 32767), rnd(-18000, 18000), "R2");
        // R3 random vectoring
        for (int k = 0; k < 500; k++)
            send(1'b1, rnd(4096, 32767), rnd(-32768, 32767), rnd(-8192, 8192), "R3");
        // R5 mixed-mode stream, back to back
        for (int k = 0; k < 600; k++) begin
            if ($urandom_range(1, 0) == 0)
                send(1'b0, rnd(-32768, 32767), rnd(-32768, 32767), rnd(-18000, 18000), "R5");
            else
                send(1'b1, rnd(4096, 32767), rnd(-32768, 32767), rnd(-8192, 8192), "R5");
        end
        // R6 sparse stream with idle gaps
        for (int k = 0; k < 200; k++) begin
            if ($urandom_range(2, 0) == 0)
                send(1'b1, rnd(4096, 32767), rnd(-32768, 32767), 0, "R6");
            else if ($urandom_range(1, 0) == 0)
                send(1'b0, rnd(-32768, 32767), rnd(-32768, 32767), rnd(-18000, 18000), "R6");
            else
                idle(rnd(1, 4));
        end
        idle(LAT + 4);
        chk(q.size() == 0, "R6", "results outstanding at end", q.size(), 0);
        summary();
        $finish;
    end

endmodule